// File: doc/BRIEF.md
# Dual-Bank Set/Clear Interrupt Controller

This block collects up to 64 interrupt sources, split into two banks of 32, and folds them into one level-sensitive fast-interrupt line for the CPU. Each bank holds a pending register and an enable register. Software never writes either register as a whole. Every register has one address that sets the bits written as one and a second address that clears them. All other bits are left untouched, so concurrent owners of different bits never need a read-modify-write.

Hardware sources raise pending bits through a per-bank 32-bit request vector. Any bit that is high on a clock edge is ORed into that bank's pending register. The bit then stays set until software clears it. The fast-interrupt output is a register that holds the OR of both banks' masked pending state. It is re-evaluated on every edge, so it responds to request arrivals and to every register write. The bank 1 summary also appears as bit 31 of the bank 0 pending read-back, which lets software find a cascade from bank 1.

Bank 0 bit positions carry fixed meanings for software:
- bits 0 and 1: vertical-blank sources
- bit 2: expansion bus
- bits 3 to 10: eight timers, with the lowest-numbered timer in bit 10
- bit 11: audio DSP
- bit 29: expansion DMA
- bit 30: software interrupt
- bit 31: secondary bank

Bank 1 bit positions:
- bit 0: player-bus DMA
- bit 1: disc inserted
- bit 2: slow bus
- bit 3: RAM-to-DSP DMA
- bits 4 to 7: auxiliary-device DMA
- bit 8: bad-bits error

Top module: `setclr_irq_ctrl`

## Requirements
- R1: After reset, every pending and enable register reads zero and `fastIrq` is low.
- R2: A write to 0x40 (bank 0) or 0x60 (bank 1) sets in that bank's pending register exactly the bits that are one in the write data. No other bit changes.
- R3: A write to 0x44 (bank 0) or 0x64 (bank 1) clears in that bank's pending register exactly the bits that are one in the write data. No other bit changes.
- R4: Writes to 0x48 and 0x68 set enable bits, and writes to 0x4C and 0x6C clear enable bits, in bank 0 and bank 1 respectively. Only the bits written as one change.
- R5: Read decoding works as follows:
  - 0x40 and 0x44 both return the bank 0 pending view.
  - 0x48 and 0x4C both return bank 0 enable.
  - 0x60 and 0x64 both return bank 1 pending.
  - 0x68 and 0x6C both return bank 1 enable.
  - Any other address reads zero.
- R6: A request bit that is high on a clock edge sets the matching pending bit of its bank. The bit stays set after the request drops, until software clears it.
- R7: When a request bit and a software clear of the same pending bit occur in the same cycle, the bit stays pending. Other bits in the clear are still cleared.
- R8: `fastIrq` is a register. After each clock edge it equals the OR over both banks of (pending AND enable) as they stand after that edge. A write or request that changes that result is therefore seen on `fastIrq` one clock later.
- R9: Clearing all of bank 0's enabled pending bits leaves `fastIrq` high while bank 1 still has an enabled pending bit.
- R10: Bit 31 of the bank 0 pending read returns one whenever bank 1 has any enabled pending bit, ORed with the stored bit 31.
- R11: Bus cycles with `busWrEn` low change no register, whatever the address and data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 8 | Byte address of the register access |
| busWrEn | input | 1 | Write strobe, one cycle per write |
| busWrData | input | 32 | Write data, interpreted as a bit mask |
| busRdData | output | 32 | Combinational read data for `busAddr` |
| reqBank0 | input | 32 | Hardware request bits for bank 0 |
| reqBank1 | input | 32 | Hardware request bits for bank 1 |
| fastIrq | output | 1 | Registered level-sensitive fast-interrupt line |

## Verification
The assertions assume that `busAddr`, `busWrEn`, `busWrData` and both request vectors are synchronous to `clk`, stable around the rising edge, and word-aligned in the address. The properties are then judged only on sampled values. They further assume that a write strobe lasts one cycle per intended access. The bench drives every input on the falling edge, holds each write for a single cycle and reads combinationally half a period after an edge. As a result, no stimulus change lands near the sampling edge.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int NUM_BANKS = 2;

  // Per-bank strobes from address decode to the register datapath
  typedef struct packed {
    logic [NUM_BANKS-1:0] setPend;
    logic [NUM_BANKS-1:0] clrPend;
    logic [NUM_BANKS-1:0] setEn;
    logic [NUM_BANKS-1:0] clrEn;
    logic [NUM_BANKS-1:0] rdPend;
    logic [NUM_BANKS-1:0] rdEn;
  } ctlStrobes_t;
endpackage

// File: rtl/intc_ctrl.sv
module intc_ctrl
  import intc_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] BANK0_BASE = 8'h40,
  parameter logic [ADDR_W-1:0] BANK_STRIDE = 8'h20
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  output ctlStrobes_t       strobes
);
  localparam logic [1:0] SLOT_SET_PEND = 2'd0;
  localparam logic [1:0] SLOT_CLR_PEND = 2'd1;
  localparam logic [1:0] SLOT_SET_EN   = 2'd2;
  localparam logic [1:0] SLOT_CLR_EN   = 2'd3;

  logic [NUM_BANKS-1:0] setPendV, clrPendV, setEnV, clrEnV, rdPendV, rdEnV;
  logic [1:0] slot;
  logic aligned;

  assign slot    = busAddr[3:2];
  assign aligned = (busAddr[1:0] == 2'b00);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam logic [ADDR_W-1:0] BASE = ADDR_W'(BANK0_BASE + b * BANK_STRIDE);
    logic hit;
    assign hit         = aligned && (busAddr[ADDR_W-1:4] == BASE[ADDR_W-1:4]);
    assign setPendV[b] = hit && busWrEn && (slot == SLOT_SET_PEND);
    assign clrPendV[b] = hit && busWrEn && (slot == SLOT_CLR_PEND);
    assign setEnV[b]   = hit && busWrEn && (slot == SLOT_SET_EN);
    assign clrEnV[b]   = hit && busWrEn && (slot == SLOT_CLR_EN);
    assign rdPendV[b]  = hit && (slot == SLOT_SET_PEND || slot == SLOT_CLR_PEND);
    assign rdEnV[b]    = hit && (slot == SLOT_SET_EN || slot == SLOT_CLR_EN);
  end

  assign strobes = '{setPend: setPendV, clrPend: clrPendV, setEn: setEnV,
                     clrEn: clrEnV, rdPend: rdPendV, rdEn: rdEnV};
endmodule

// File: rtl/intc_bank.sv
module intc_bank #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              setPend,
  input  logic              clrPend,
  input  logic              setEn,
  input  logic              clrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] req,
  output logic [DATA_W-1:0] pend,
  output logic [DATA_W-1:0] en,
  output logic              active,
  output logic              activeNext
);
  logic [DATA_W-1:0] pendNext, enNext, setMaskP, clrMaskP, setMaskE, clrMaskE;

  assign setMaskP = setPend ? wrData : '0;
  assign clrMaskP = clrPend ? wrData : '0;
  assign setMaskE = setEn ? wrData : '0;
  assign clrMaskE = clrEn ? wrData : '0;

  // A request in the same cycle as a clear keeps the bit pending
  assign pendNext   = (pend & ~clrMaskP) | setMaskP | req;
  assign enNext     = (en & ~clrMaskE) | setMaskE;
  assign activeNext = |(pendNext & enNext);
  assign active     = |(pend & en);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pend <= '0;
      en   <= '0;
    end else begin
      pend <= pendNext;
      en   <= enNext;
    end
  end
endmodule

// File: rtl/intc_datapath.sv
module intc_datapath
  import intc_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  ctlStrobes_t                         strobes,
  input  logic [DATA_W-1:0]                   wrData,
  input  logic [NUM_BANKS-1:0][DATA_W-1:0]    reqVec,
  output logic [NUM_BANKS-1:0][DATA_W-1:0]    pendVec,
  output logic [NUM_BANKS-1:0][DATA_W-1:0]    enVec,
  output logic [DATA_W-1:0]                   rdData,
  output logic                                fastIrq
);
  logic [NUM_BANKS-1:0] active, activeNext;
  logic [NUM_BANKS-1:0][DATA_W-1:0] pendView;
  logic cascade;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    intc_bank #(.DATA_W(DATA_W)) u_bank (
      .clk        (clk),
      .rstN       (rstN),
      .setPend    (strobes.setPend[b]),
      .clrPend    (strobes.clrPend[b]),
      .setEn      (strobes.setEn[b]),
      .clrEn      (strobes.clrEn[b]),
      .wrData     (wrData),
      .req        (reqVec[b]),
      .pend       (pendVec[b]),
      .en         (enVec[b]),
      .active     (active[b]),
      .activeNext (activeNext[b])
    );
  end

  // Secondary-bank summary folded into the top bit of the bank 0 view
  assign cascade = |active[NUM_BANKS-1:1];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_view
    if (b == 0) begin : g_primary
      assign pendView[b] = pendVec[b] | {cascade, {(DATA_W-1){1'b0}}};
    end else begin : g_secondary
      assign pendView[b] = pendVec[b];
    end
  end

  always_comb begin
    rdData = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (strobes.rdPend[b]) rdData = rdData | pendView[b];
      if (strobes.rdEn[b])   rdData = rdData | enVec[b];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) fastIrq <= 1'b0;
    else       fastIrq <= |activeNext;
  end
endmodule

// File: rtl/setclr_irq_ctrl.sv
module setclr_irq_ctrl
  import intc_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] BANK0_BASE = 8'h40,
  parameter logic [ADDR_W-1:0] BANK_STRIDE = 8'h20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  input  logic [DATA_W-1:0] reqBank0,
  input  logic [DATA_W-1:0] reqBank1,
  output logic              fastIrq
);
  ctlStrobes_t strobes;
  logic [NUM_BANKS-1:0][DATA_W-1:0] reqVec, pendVec, enVec;

  assign reqVec[0] = reqBank0;
  assign reqVec[1] = reqBank1;

  intc_ctrl #(
    .ADDR_W(ADDR_W), .BANK0_BASE(BANK0_BASE), .BANK_STRIDE(BANK_STRIDE)
  ) u_ctrl (
    .busAddr (busAddr),
    .busWrEn (busWrEn),
    .strobes (strobes)
  );

  intc_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .wrData  (busWrData),
    .reqVec  (reqVec),
    .pendVec (pendVec),
    .enVec   (enVec),
    .rdData  (busRdData),
    .fastIrq (fastIrq)
  );
endmodule

// File: rtl/setclr_irq_ctrl_chk.sv
module setclr_irq_ctrl_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] BANK0_BASE = 8'h40,
  parameter logic [ADDR_W-1:0] BANK_STRIDE = 8'h20
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWrEn,
  input logic [DATA_W-1:0] busRdData,
  input logic [DATA_W-1:0] reqBank0,
  input logic [DATA_W-1:0] reqBank1,
  input logic              fastIrq,
  input logic [DATA_W-1:0] pend0,
  input logic [DATA_W-1:0] en0,
  input logic [DATA_W-1:0] pend1,
  input logic [DATA_W-1:0] en1
);
  localparam logic [ADDR_W-1:0] PEND0_ADDR  = BANK0_BASE;
  localparam logic [ADDR_W-1:0] CLRP0_ADDR  = ADDR_W'(BANK0_BASE + 4);
  localparam logic [ADDR_W-1:0] CLRP1_ADDR  = ADDR_W'(BANK0_BASE + BANK_STRIDE + 4);

  // R8
  irq_level_chk: assert property (@(posedge clk) disable iff (!rstN)
    fastIrq == ((|(pend0 & en0)) || (|(pend1 & en1))));

  // R6
  pend0_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(busWrEn && busAddr == CLRP0_ADDR) |=> (($past(pend0) & ~pend0) == '0));

  // R6
  req0_capture_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((pend0 & $past(reqBank0)) == $past(reqBank0)));

  // R7
  req1_beats_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == CLRP1_ADDR) |=> ((pend1 & $past(reqBank1)) == $past(reqBank1)));

  // R11
  idle_bus_enable_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busWrEn |=> ($stable(en0) && $stable(en1)));

  // R10
  cascade_view_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == PEND0_ADDR && (|(pend1 & en1))) |-> busRdData[DATA_W-1]);
endmodule

bind setclr_irq_ctrl setclr_irq_ctrl_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BANK0_BASE(BANK0_BASE), .BANK_STRIDE(BANK_STRIDE)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .busAddr   (busAddr),
  .busWrEn   (busWrEn),
  .busRdData (busRdData),
  .reqBank0  (reqBank0),
  .reqBank1  (reqBank1),
  .fastIrq   (fastIrq),
  .pend0     (pendVec[0]),
  .en0       (enVec[0]),
  .pend1     (pendVec[1]),
  .en1       (enVec[1])
);

// File: tb/setclr_irq_ctrl_test.sv
`timescale 1ns/1ps
module setclr_irq_ctrl_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  busAddr = '0;
  logic        busWrEn = 1'b0;
  logic [31:0] busWrData = '0;
  logic [31:0] reqBank0 = '0;
  logic [31:0] reqBank1 = '0;
  logic [31:0] busRdData;
  logic        fastIrq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [31:0] mP0 = '0, mE0 = '0, mP1 = '0, mE1 = '0;

  always #2 clk = ~clk;

  setclr_irq_ctrl uut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData), .reqBank0(reqBank0),
    .reqBank1(reqBank1), .fastIrq(fastIrq)
  );

  // {address, data} write vectors
  localparam int NVEC = 12;
  localparam logic [39:0] VEC [NVEC] = '{
    {8'h48, 32'h0000_00F0}, {8'h40, 32'h0000_0101}, {8'h40, 32'h0000_0010},
    {8'h4C, 32'h0000_0010}, {8'h48, 32'h0000_0100}, {8'h44, 32'h0000_0100},
    {8'h68, 32'h0000_0003}, {8'h60, 32'h0000_0002}, {8'h48, 32'h0000_0001},
    {8'h44, 32'h0000_0111}, {8'h64, 32'h0000_0002}, {8'h6C, 32'h0000_0001}
  };

  function automatic logic [31:0] expRead(logic [7:0] a);
    case (a)
      8'h40, 8'h44: return mP0 | {(|(mP1 & mE1)), 31'b0};
      8'h48, 8'h4C: return mE0;
      8'h60, 8'h64: return mP1;
      8'h68, 8'h6C: return mE1;
      default:      return 32'h0;
    endcase
  endfunction

  function automatic logic expIrq();
    return (|(mP0 & mE0)) | (|(mP1 & mE1));
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic modelWr(logic [7:0] a, logic [31:0] d);
    case (a)
      8'h40: mP0 = mP0 | d;
      8'h44: mP0 = mP0 & ~d;
      8'h48: mE0 = mE0 | d;
      8'h4C: mE0 = mE0 & ~d;
      8'h60: mP1 = mP1 | d;
      8'h64: mP1 = mP1 & ~d;
      8'h68: mE1 = mE1 | d;
      8'h6C: mE1 = mE1 & ~d;
      default: ;
    endcase
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
    modelWr(a, d);
  endtask

  task automatic rdChk(string tag, logic [7:0] a);
    busAddr = a;
    #1;
    chk(tag, busRdData, expRead(a));
  endtask

  task automatic irqChk(string tag);
    chk(tag, {31'b0, fastIrq}, {31'b0, expIrq()});
  endtask

  task automatic pulseReq(logic [31:0] r0, logic [31:0] r1);
    @(negedge clk);
    reqBank0 = r0; reqBank1 = r1;
    @(negedge clk);
    reqBank0 = '0; reqBank1 = '0;
    mP0 = mP0 | r0; mP1 = mP1 | r1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    rdChk("R1 pend0 after reset", 8'h40);
    rdChk("R1 en0 after reset", 8'h48);
    rdChk("R1 pend1 after reset", 8'h60);
    rdChk("R1 en1 after reset", 8'h68);
    irqChk("R1 fastIrq after reset");

    // Table walk: R2 R3 R4 R5 R8 R9 R10 -- read back through the alias address
    for (int i = 0; i < NVEC; i++) begin
      wr(VEC[i][39:32], VEC[i][31:0]);
      rdChk("R2/R3/R4/R5 readback via alias", VEC[i][39:32] ^ 8'h04);
      irqChk("R8/R9 fastIrq after table write");
    end

    // R10 cascade bit seen at the other pending alias
    wr(8'h60, 32'h0000_0001);
    wr(8'h68, 32'h0000_0001);
    rdChk("R10 cascade bit at bank0 pending", 8'h40);
    chk("R10 bit31 set", {31'b0, busRdData[31]}, 32'h1);
    // R9 bank0 has nothing enabled but bank1 keeps the line up
    wr(8'h44, 32'hFFFF_FFFF);
    irqChk("R9 line held by bank1");
    chk("R9 line high", {31'b0, fastIrq}, 32'h1);

    // R5 unmapped address
    rdChk("R5 unmapped read zero", 8'h50);
    rdChk("R5 unmapped read zero", 8'h42);

    // R11 writes with strobe low are ignored
    @(negedge clk);
    busAddr = 8'h48; busWrData = 32'hFFFF_FFFF; busWrEn = 1'b0;
    @(negedge clk);
    busAddr = 8'h68;
    @(negedge clk);
    rdChk("R11 en0 unchanged", 8'h48);
    rdChk("R11 en1 unchanged", 8'h68);

    // Clear everything for the request tests
    wr(8'h44, 32'hFFFF_FFFF); wr(8'h4C, 32'hFFFF_FFFF);
    wr(8'h64, 32'hFFFF_FFFF); wr(8'h6C, 32'hFFFF_FFFF);
    irqChk("R3/R4 all cleared");

    // R8 latency: request raised, line rises only after the next edge
    wr(8'h48, 32'h0000_0008);
    @(negedge clk);
    reqBank0 = 32'h0000_0008;
    #1;
    chk("R8 no change before edge", {31'b0, fastIrq}, 32'h0);
    @(negedge clk);
    reqBank0 = '0;
    mP0 = mP0 | 32'h0000_0008;
    chk("R8 high one clock later", {31'b0, fastIrq}, 32'h1);

    // R6 request captured and sticky
    pulseReq(32'h0010_0000, 32'h0000_0100);
    repeat (4) @(negedge clk);
    rdChk("R6 bank0 request sticky", 8'h44);
    rdChk("R6 bank1 request sticky", 8'h64);

    // R7 request beats same-cycle clear; other cleared bits still go
    wr(8'h60, 32'h0000_0040);
    @(negedge clk);
    busAddr = 8'h64; busWrData = 32'h0000_0160; busWrEn = 1'b1;
    reqBank1 = 32'h0000_0020;
    @(negedge clk);
    busWrEn = 1'b0; reqBank1 = '0;
    mP1 = (mP1 & ~32'h0000_0160) | 32'h0000_0020;
    rdChk("R7 request wins over clear", 8'h60);

    // R3 clear of bank0 drops the line when nothing else is enabled
    wr(8'h44, 32'h0000_0008);
    irqChk("R3/R8 line drops after clear");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R1 watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule